// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This block resolves the compare and branch instructions of a small 32-bit register machine. A compare subtracts its second operand from its first and stores four condition flags: zero, sign, carry (borrow) and signed overflow. The second operand comes either from a register or from an immediate, depending on the opcode. A branch instruction carries a 12-bit opcode and a target address. The block decides, from the stored flags, whether the branch is taken. The one exception is the count-zero branch, which tests a count register operand and ignores the flags.

Every result is combinational and appears in the same cycle the instruction is presented with `valid_i` high. The outputs are the next-PC select (`taken_o`), the target address and the cycle cost of the instruction. Only the flag register is clocked, and it loads on the rising edge that accepts a compare. Floating-point compares, the register file and instruction fetch live outside the block.

Top module: `cmp_branch_unit`

## Requirements
- R1: Opcode 0xC01 compares `op_a_i` with `op_b_i`. Opcode 0xC02 compares `op_a_i` with `imm_i`. The flags load on the clock edge that accepts the compare and are visible on `flags_o` from the next cycle.
- R2: A compare computes A−B modulo 2^32. `flags_o[0]` (ZF) is set when the result is zero. `flags_o[1]` (SF) is result bit 31. `flags_o[2]` (OF) is signed overflow of the subtraction. `flags_o[3]` (CF) is the borrow, set when A < B unsigned.
- R3: The flags keep their value through every cycle that is not an accepted compare. This covers branches, illegal opcodes and cycles with `valid_i` low.
- R4: Opcode 0xC00 is always taken.
- R5: The signed branches are taken under these conditions. 0xC07: ZF clear and SF equals OF. 0xC08: SF equals OF. 0xC09: SF differs from OF. 0xC0A: ZF set or SF differs from OF.
- R6: The unsigned branches are taken under these conditions. 0xC0B: CF and ZF both clear. 0xC0C: CF clear. 0xC0D: CF set. 0xC0E: CF or ZF set.
- R7: 0xC05 is taken on ZF set and 0xC06 on ZF clear. 0xC0F is taken on CF set and 0xC10 on CF clear. 0xC11 is taken on OF set and 0xC12 on OF clear. 0xC13 is taken on SF set and 0xC14 on SF clear.
- R8: Opcode 0xCFF is taken exactly when `count_i` is zero, whatever the flags hold.
- R9: Every other opcode raises `illegal_o`, is never taken and changes no flag. This includes 0xC03, 0xC04 and 0xC15 to 0xCFE.
- R10: `cost_o` reports the instruction's cost. Compares and 0xC00 cost 1. Conditional branches and 0xCFF cost 2. Illegal opcodes cost 0.
- R11: With `valid_i` low, `taken_o`, `illegal_o` and `cost_o` are zero. `target_o` equals `target_i` when taken and is zero otherwise.
- R12: After reset all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| opcode_i | input | 12 | Instruction opcode |
| op_a_i | input | 32 | First compare operand |
| op_b_i | input | 32 | Second register operand |
| imm_i | input | 32 | Immediate second operand |
| count_i | input | 32 | Count register value |
| target_i | input | 32 | Branch target address |
| taken_o | output | 1 | Next-PC select, 1 selects the target |
| target_o | output | 32 | Target when taken, else zero |
| cost_o | output | 2 | Cycle cost of the instruction |
| illegal_o | output | 1 | Opcode not supported |
| flags_o | output | 4 | Stored flags {CF, OF, SF, ZF} |

## Verification
A wrong flag bit stays hidden until a branch reads it. It then shows at `taken_o` in the first branch cycle after the compare. Flags are also exposed directly on `flags_o` one cycle after the compare. Each condition is therefore driven right after compares chosen to give each flag combination: equal, unsigned borrow with signed less, and signed overflow both ways. An illegal opcode that disturbed the flags would show as a changed `flags_o` one cycle later.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OPC_W  = 12;
  localparam int unsigned COST_W = 2;
  localparam int unsigned COND_N = 16;
  localparam int unsigned COND_W = $clog2(COND_N);

  localparam logic [OPC_W-1:0] OP_JMP    = 12'hC00;
  localparam logic [OPC_W-1:0] OP_CMP_RR = 12'hC01;
  localparam logic [OPC_W-1:0] OP_CMP_RI = 12'hC02;
  localparam logic [OPC_W-1:0] OP_JCC_LO = 12'hC05;
  localparam logic [OPC_W-1:0] OP_JCC_HI = 12'hC14;
  localparam logic [OPC_W-1:0] OP_JCZ    = 12'hCFF;

  localparam logic [COST_W-1:0] COST_CMP = 2'd1;
  localparam logic [COST_W-1:0] COST_JMP = 2'd1;
  localparam logic [COST_W-1:0] COST_JCC = 2'd2;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_CMP_RR,
    CLS_CMP_RI,
    CLS_JMP,
    CLS_JCC,
    CLS_JCZ,
    CLS_ILL
  } ins_cls_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
  } flags_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic                valid_i,
  input  logic [OPC_W-1:0]    opcode_i,
  output ins_cls_e            cls_o,
  output logic [COND_W-1:0]   cond_o,
  output logic [COST_W-1:0]   cost_o
);
  always_comb begin
    cls_o = CLS_NONE;
    if (valid_i) begin
      if (opcode_i == OP_JMP)                                  cls_o = CLS_JMP;
      else if (opcode_i == OP_CMP_RR)                          cls_o = CLS_CMP_RR;
      else if (opcode_i == OP_CMP_RI)                          cls_o = CLS_CMP_RI;
      else if (opcode_i >= OP_JCC_LO && opcode_i <= OP_JCC_HI) cls_o = CLS_JCC;
      else if (opcode_i == OP_JCZ)                             cls_o = CLS_JCZ;
      else                                                     cls_o = CLS_ILL;
    end
  end

  // low nibble rebased so 0xC05 maps to index 0, 0xC14 to 15
  assign cond_o = opcode_i[COND_W-1:0] - OP_JCC_LO[COND_W-1:0];

  always_comb begin
    unique case (cls_o)
      CLS_CMP_RR, CLS_CMP_RI: cost_o = COST_CMP;
      CLS_JMP:                cost_o = COST_JMP;
      CLS_JCC, CLS_JCZ:       cost_o = COST_JCC;
      default:                cost_o = '0;
    endcase
  end
endmodule

// File: rtl/cbu_flag_unit.sv
module cbu_flag_unit
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0]   diff_ext;
  logic [DATA_W-1:0] diff;
  flags_t            flags_d, flags_q;

  assign diff_ext = {1'b0, a_i} - {1'b0, b_i};
  assign diff     = diff_ext[DATA_W-1:0];

  always_comb begin
    flags_d.zf = (diff == '0);
    flags_d.sf = diff[MSB];
    flags_d.cf = diff_ext[DATA_W];
    flags_d.of = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ a_i[MSB]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (load_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r3_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flags_q));
  a_r2_zero_on_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && a_i == b_i) |=> (flags_q.zf && !flags_q.cf && !flags_q.of));
  a_r2_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && a_i < b_i) |=> flags_q.cf);
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  flags_t              flags_i,
  input  ins_cls_e            cls_i,
  input  logic [COND_W-1:0]   cond_i,
  input  logic [DATA_W-1:0]   count_i,
  output logic                taken_o
);
  logic [COND_N-1:0] cv;
  logic              s_ne_o;

  assign s_ne_o = flags_i.sf ^ flags_i.of;

  // pairs {true, negated}: index order follows opcode order
  assign cv[0]  =  flags_i.zf;
  assign cv[1]  = ~flags_i.zf;
  assign cv[2]  = ~flags_i.zf & ~s_ne_o;
  assign cv[3]  = ~s_ne_o;
  assign cv[4]  =  s_ne_o;
  assign cv[5]  =  flags_i.zf | s_ne_o;
  assign cv[6]  = ~flags_i.cf & ~flags_i.zf;
  assign cv[7]  = ~flags_i.cf;
  assign cv[8]  =  flags_i.cf;
  assign cv[9]  =  flags_i.cf | flags_i.zf;
  assign cv[10] =  flags_i.cf;
  assign cv[11] = ~flags_i.cf;
  assign cv[12] =  flags_i.of;
  assign cv[13] = ~flags_i.of;
  assign cv[14] =  flags_i.sf;
  assign cv[15] = ~flags_i.sf;

  always_comb begin
    unique case (cls_i)
      CLS_JMP: taken_o = 1'b1;
      CLS_JCC: taken_o = cv[cond_i];
      CLS_JCZ: taken_o = (count_i == '0);
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned ADDR_W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [11:0]       opcode_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [1:0]        cost_o,
  output logic              illegal_o,
  output logic [3:0]        flags_o
);
  ins_cls_e          cls;
  logic [COND_W-1:0] cond;
  logic              cmp_load;
  logic [DATA_W-1:0] cmp_b;
  flags_t            flags;

  cbu_decode u_dec (
    .valid_i (valid_i),
    .opcode_i(opcode_i),
    .cls_o   (cls),
    .cond_o  (cond),
    .cost_o  (cost_o)
  );

  assign cmp_load = (cls == CLS_CMP_RR) || (cls == CLS_CMP_RI);
  assign cmp_b    = (cls == CLS_CMP_RI) ? imm_i : op_b_i;

  cbu_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmp_load),
    .a_i    (op_a_i),
    .b_i    (cmp_b),
    .flags_o(flags)
  );

  cbu_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .flags_i(flags),
    .cls_i  (cls),
    .cond_i (cond),
    .count_i(count_i),
    .taken_o(taken_o)
  );

  assign illegal_o = (cls == CLS_ILL);
  assign target_o  = taken_o ? target_i : '0;
  assign flags_o   = flags;

  a_r9_illegal_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && cost_o == '0));
  a_r9_illegal_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(flags_o));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!taken_o && !illegal_o && cost_o == '0 && target_o == '0));
  a_r8_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_JCZ) |-> (taken_o == (count_i == '0)));
  a_r4_jmp_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_JMP) |-> (taken_o && cost_o == COST_JMP));
endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [11:0] opc;
  logic [31:0] a, b, imm, cnt, tgt;
  logic        taken, illegal;
  logic [31:0] tgt_o;
  logic [1:0]  cost;
  logic [3:0]  flags;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opc),
    .op_a_i(a), .op_b_i(b), .imm_i(imm), .count_i(cnt), .target_i(tgt),
    .taken_o(taken), .target_o(tgt_o), .cost_o(cost), .illegal_o(illegal),
    .flags_o(flags)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [11:0] op;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // R7 equal operands
    '{32'd5, 32'd5, 12'hC05, 1'b1, 8'd7},
    '{32'd5, 32'd5, 12'hC06, 1'b0, 8'd7},
    // 3-7: ZF0 SF1 CF1 OF0 -> R5 R6 R7
    '{32'd3, 32'd7, 12'hC07, 1'b0, 8'd5},
    '{32'd3, 32'd7, 12'hC08, 1'b0, 8'd5},
    '{32'd3, 32'd7, 12'hC09, 1'b1, 8'd5},
    '{32'd3, 32'd7, 12'hC0A, 1'b1, 8'd5},
    '{32'd3, 32'd7, 12'hC0B, 1'b0, 8'd6},
    '{32'd3, 32'd7, 12'hC0C, 1'b0, 8'd6},
    '{32'd3, 32'd7, 12'hC0D, 1'b1, 8'd6},
    '{32'd3, 32'd7, 12'hC0E, 1'b1, 8'd6},
    '{32'd3, 32'd7, 12'hC0F, 1'b1, 8'd7},
    '{32'd3, 32'd7, 12'hC10, 1'b0, 8'd7},
    '{32'd3, 32'd7, 12'hC11, 1'b0, 8'd7},
    '{32'd3, 32'd7, 12'hC12, 1'b1, 8'd7},
    '{32'd3, 32'd7, 12'hC13, 1'b1, 8'd7},
    '{32'd3, 32'd7, 12'hC14, 1'b0, 8'd7},
    // 0x80000000-1: OF1 SF0 CF0 ZF0
    '{32'h8000_0000, 32'd1, 12'hC07, 1'b0, 8'd5},
    '{32'h8000_0000, 32'd1, 12'hC09, 1'b1, 8'd5},
    '{32'h8000_0000, 32'd1, 12'hC11, 1'b1, 8'd7},
    '{32'h8000_0000, 32'd1, 12'hC0B, 1'b1, 8'd6},
    // 7-3: all clear
    '{32'd7, 32'd3, 12'hC07, 1'b1, 8'd5},
    '{32'd7, 32'd3, 12'hC08, 1'b1, 8'd5},
    '{32'd7, 32'd3, 12'hC0A, 1'b0, 8'd5},
    '{32'd7, 32'd3, 12'hC0B, 1'b1, 8'd6},
    '{32'd7, 32'd3, 12'hC0E, 1'b0, 8'd6},
    // 1 - 0xFFFFFFFF: CF1, signed greater
    '{32'd1, 32'hFFFF_FFFF, 12'hC07, 1'b1, 8'd5},
    '{32'd1, 32'hFFFF_FFFF, 12'hC0B, 1'b0, 8'd6},
    '{32'd1, 32'hFFFF_FFFF, 12'hC0D, 1'b1, 8'd6},
    // equal: LE and BE via ZF
    '{32'd9, 32'd9, 12'hC0A, 1'b1, 8'd5},
    '{32'd9, 32'd9, 12'hC0E, 1'b1, 8'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [11:0] o, input logic [31:0] aa,
                       input logic [31:0] bb, input logic [31:0] ii, input logic [31:0] cc);
    @(negedge clk);
    valid = v; opc = o; a = aa; b = bb; imm = ii; cnt = cc;
    #1;
  endtask

  task automatic idle();
    issue(1'b0, 12'h000, 32'd0, 32'd0, 32'd0, 32'd1);
  endtask

  initial begin
    valid = 0; opc = '0; a = '0; b = '0; imm = '0; cnt = 32'd1; tgt = 32'h0000_4000;
    repeat (3) @(negedge clk);
    chk("R12 reset flags", {28'd0, flags}, 32'd0);
    chk("R11 idle taken", {31'd0, taken}, 32'd0);
    rst_n = 1'b1;
    idle();
    chk("R12 flags after release", {28'd0, flags}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, 12'hC01, VEC[i].a, VEC[i].b, 32'd0, 32'd1);
      chk("R10 cmp cost", {30'd0, cost}, 32'd1);
      issue(1'b1, VEC[i].op, 32'd0, 32'd0, 32'd0, 32'd1);
      checks++;
      if (taken !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d op %h row %0d: actual %b expected %b",
                 VEC[i].req, VEC[i].op, i, taken, VEC[i].exp);
      end
      chk("R10 jcc cost", {30'd0, cost}, 32'd2);
    end

    // R1 R2 immediate compare ignores op_b_i: 3 - imm 7
    issue(1'b1, 12'hC02, 32'd3, 32'd3, 32'd7, 32'd1);
    idle();
    chk("R1 imm flags", {28'd0, flags}, 32'b1010);
    // R2 overflow case 0x80000000-1 -> {CF0,OF1,SF0,ZF0}
    issue(1'b1, 12'hC01, 32'h8000_0000, 32'd1, 32'd0, 32'd1);
    idle();
    chk("R2 overflow flags", {28'd0, flags}, 32'b0100);
    // R2 positive-minus-negative overflow: 0x7FFFFFFF - 0xFFFFFFFF = 0x80000000
    issue(1'b1, 12'hC01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd1);
    idle();
    chk("R2 pos-neg flags", {28'd0, flags}, 32'b1110);

    // R3 flags held over branch, idle compare opcode and illegal
    issue(1'b1, 12'hC01, 32'd5, 32'd5, 32'd0, 32'd1);
    issue(1'b1, 12'hC06, 32'd0, 32'd0, 32'd0, 32'd1);
    issue(1'b0, 12'hC01, 32'd1, 32'd2, 32'd0, 32'd1);
    chk("R11 idle cost", {30'd0, cost}, 32'd0);
    issue(1'b1, 12'hC15, 32'd1, 32'd2, 32'd0, 32'd1);
    idle();
    chk("R3 flags held", {28'd0, flags}, 32'b0001);

    // R4 unconditional
    issue(1'b1, 12'hC00, 32'd0, 32'd0, 32'd0, 32'd1);
    chk("R4 jmp taken", {31'd0, taken}, 32'd1);
    chk("R4 jmp target", tgt_o, 32'h0000_4000);
    chk("R10 jmp cost", {30'd0, cost}, 32'd1);

    // R8 count zero, flags currently ZF=1
    issue(1'b1, 12'hCFF, 32'd0, 32'd0, 32'd0, 32'd0);
    chk("R8 count zero taken", {31'd0, taken}, 32'd1);
    chk("R10 jcz cost", {30'd0, cost}, 32'd2);
    issue(1'b1, 12'hCFF, 32'd0, 32'd0, 32'd0, 32'd5);
    chk("R8 count nonzero", {31'd0, taken}, 32'd0);
    chk("R11 target zero not taken", tgt_o, 32'd0);

    // R9 illegal opcodes
    issue(1'b1, 12'hC03, 32'd1, 32'd9, 32'd0, 32'd0);
    chk("R9 C03 illegal", {31'd0, illegal}, 32'd1);
    chk("R9 C03 not taken", {31'd0, taken}, 32'd0);
    chk("R9 C03 cost", {30'd0, cost}, 32'd0);
    issue(1'b1, 12'hCFE, 32'd1, 32'd9, 32'd0, 32'd0);
    chk("R9 CFE illegal", {31'd0, illegal}, 32'd1);
    issue(1'b1, 12'h123, 32'd1, 32'd9, 32'd0, 32'd0);
    chk("R9 other illegal", {31'd0, illegal}, 32'd1);
    idle();
    chk("R9 flags unchanged", {28'd0, flags}, 32'b0001);
    chk("R11 idle illegal", {31'd0, illegal}, 32'd0);

    // R12 reset clears set flags
    issue(1'b1, 12'hC01, 32'd3, 32'd7, 32'd0, 32'd1);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R12 async reset", {28'd0, flags}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule